// File: doc/BRIEF.md
# Seconds Counter with Alarm Match

This block keeps a 32-bit count of elapsed seconds for a chip that has a slow time-base tick. A prescaler divides a 32.768 kHz tick enable down to one step per second. The count advances only while software has set the enable bit in the control word. Software can preload the count, read it back, and program a match value. The alarm flag is raised while the count equals the match value.

Two interrupt sources share one set of status registers. Bit 0 is the alarm and bit 1 is the periodic one-second event. Each source has a raw bit, a mask bit, and a masked view. A write-one-to-clear register clears the raw bits. The single interrupt line is the OR of the masked bits.

Register access uses a plain strobe interface. A write takes effect at the clock edge that samples `we_i`. Read data appears on `rdata_o` one cycle after `re_i` is sampled, and is then held.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, the count reads 0, the match value reads 0xFFFFFFFF, and load, control, mask, raw and masked all read 0. The output `irq_o` is low.
- R2: Registers are decoded from `addr_i` as word-aligned byte offsets:
  - 0x00 returns the running count.
  - 0x04 is the match value.
  - 0x08 sets the count; a read returns the last value loaded.
  - 0x0C is control.
  - 0x10 is the interrupt mask.
  - 0x14 is raw status.
  - 0x18 is masked status.
  - 0x1C is the clear register.

  Writes to 0x00, 0x14 and 0x18 are ignored.
- R3: While control bit 26 is 1, the count increments by one for every PRESCALE cycles in which `tick_en_i` is high. Those cycles need not be contiguous. While bit 26 is 0, neither the count nor the prescaler phase moves.
- R4: A write to the load register sets the count at that edge and restarts the prescaler phase at zero. The next advance therefore needs a full PRESCALE ticks. If the prescaler would complete in the same cycle as the load write, the load wins and that second is dropped.
- R5: The count wraps from 0xFFFFFFFF to 0 on advance.
- R6: Raw bit 0 is set on the edge after any cycle in which the count equals the match value. It is therefore re-set every cycle for as long as the two stay equal.
- R7: Raw bit 1 is set on the edge after each one-second advance of the count.
- R8: Writing 1 to a bit of the clear register (0x1C) clears that raw bit, and writing 0 leaves it unchanged. When a set condition and a clear fall in the same cycle, the bit stays set. The clear register reads 0.
- R9: Masked status reads as raw AND mask over bits 1:0. `irq_o` is high exactly when any masked bit is 1.
- R10: A read returns its data one cycle after `re_i`. Control reads only bit 26, with all other bits 0. Unaligned addresses, or addresses at 0x20 and above, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Time-base tick enable, nominally 32.768 kHz |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Interrupt, OR of masked status |

## Verification
The bench uses a prescale of 4 and applies the tick enable in three patterns:
- Back-to-back pulses give a clean divide-by-4.
- Gapped pulses show that the divider counts pulses, not clock cycles.
- Pulses with the enable bit cleared confirm that everything holds.

Load writes are placed at a fresh phase, mid-phase, and in the exact cycle the prescaler completes. This separates "load restarts the phase" from "load beats the advance". Clear writes are issued both while the set condition still holds and after it has gone, which distinguishes set-wins from plain clearing. A sweep over all four mask values against known raw states checks the masked view and the interrupt line.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int BUS_W       = 32;
  localparam int IRQ_N       = 2;
  localparam int IRQ_ALARM   = 0;
  localparam int IRQ_PERIOD  = 1;
  localparam int CTRL_EN_BIT = 26;

  // word index, addr[4:2]
  typedef enum logic [2:0] {
    REG_COUNT  = 3'd0,
    REG_MATCH  = 3'd1,
    REG_LOAD   = 3'd2,
    REG_CTRL   = 3'd3,
    REG_MASK   = 3'd4,
    REG_RAW    = 3'd5,
    REG_MSKD   = 3'd6,
    REG_CLEAR  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_en_i,
  input  logic restart_i,
  output logic sec_tick_o
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] phase_q;
  logic          step;
  logic          wrap;

  assign step       = en_i && tick_en_i;
  assign wrap       = step && (phase_q == LAST);
  assign sec_tick_o = wrap && !restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (step)      phase_q <= wrap ? '0 : phase_q + 1'b1;
  end

  assert_hold_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !restart_i) |=> $stable(phase_q));

  assert_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (phase_q == '0));

  assert_load_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |-> !sec_tick_o);
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  assert_step_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] mask_o,
  output logic [N-1:0] masked_o,
  output logic         irq_o
);
  logic [N-1:0] raw_q;
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_q[i] <= 1'b0;
      else         raw_q[i] <= set_i[i] | (raw_q[i] & ~clr_i[i]);
    end

    assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> raw_q[i]);

    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !set_i[i]) |=> !raw_q[i]);

    assert_no_spurious_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!raw_q[i] && !set_i[i]) |=> !raw_q[i]);
  end

  assign masked_o = raw_q & mask_q;
  assign irq_o    = |masked_o;
  assign raw_o    = raw_q;
  assign mask_o   = mask_q;
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_sec_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int PRESCALE = 32768
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int CNT_W = BUS_W;

  reg_sel_e         sel;
  logic             addr_ok;
  logic             wr_en;
  logic             load_we;
  logic [CNT_W-1:0] match_q;
  logic [CNT_W-1:0] load_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic             sec_tick;
  logic [IRQ_N-1:0] set_vec;
  logic [IRQ_N-1:0] clr_vec;
  logic [IRQ_N-1:0] raw;
  logic [IRQ_N-1:0] mask;
  logic [IRQ_N-1:0] masked;
  logic [BUS_W-1:0] ctrl_word;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;

  assign sel     = reg_sel_e'(addr_i[4:2]);
  assign addr_ok = (addr_i[ADDR_W-1:5] == '0) && (addr_i[1:0] == 2'b00);
  assign wr_en   = we_i && addr_ok;
  assign load_we = wr_en && (sel == REG_LOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= '1;
      load_q  <= '0;
      en_q    <= 1'b0;
    end else if (wr_en) begin
      case (sel)
        REG_MATCH: match_q <= wdata_i;
        REG_LOAD:  load_q  <= wdata_i;
        REG_CTRL:  en_q    <= wdata_i[CTRL_EN_BIT];
        default: ;
      endcase
    end
  end

  rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_q),
    .tick_en_i  (tick_en_i),
    .restart_i  (load_we),
    .sec_tick_o (sec_tick)
  );

  rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_we),
    .load_val_i (wdata_i),
    .step_i     (sec_tick),
    .cnt_o      (cnt)
  );

  always_comb begin
    set_vec             = '0;
    set_vec[IRQ_ALARM]  = (cnt == match_q);
    set_vec[IRQ_PERIOD] = sec_tick;
  end

  assign clr_vec = (wr_en && sel == REG_CLEAR) ? wdata_i[IRQ_N-1:0] : '0;

  rtc_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .mask_we_i (wr_en && sel == REG_MASK),
    .mask_i    (wdata_i[IRQ_N-1:0]),
    .raw_o     (raw),
    .mask_o    (mask),
    .masked_o  (masked),
    .irq_o     (irq_o)
  );

  always_comb begin
    ctrl_word              = '0;
    ctrl_word[CTRL_EN_BIT] = en_q;
  end

  always_comb begin
    case (sel)
      REG_COUNT: rd_mux = cnt;
      REG_MATCH: rd_mux = match_q;
      REG_LOAD:  rd_mux = load_q;
      REG_CTRL:  rd_mux = ctrl_word;
      REG_MASK:  rd_mux = BUS_W'(mask);
      REG_RAW:   rd_mux = BUS_W'(raw);
      REG_MSKD:  rd_mux = BUS_W'(masked);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= addr_ok ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;

  assert_read_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_ok && sel == REG_COUNT) |=> (rdata_o == $past(cnt)));

  assert_alarm_raw_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == match_q) |=> raw[IRQ_ALARM]);

  assert_period_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick |=> raw[IRQ_PERIOD]);

  assert_read_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_rtc_sec_alarm.sv
module sim_rtc_sec_alarm;
  localparam int PS = 4;
  localparam logic [7:0] A_CNT = 8'h00, A_MAT = 8'h04, A_LD = 8'h08, A_CTL = 8'h0C,
                         A_MSK = 8'h10, A_RAW = 8'h14, A_MSD = 8'h18, A_CLR = 8'h1C;
  localparam logic [31:0] EN = 32'h0400_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          errors = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  rtc_sec_alarm #(.ADDR_W(8), .PRESCALE(PS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .re_i(re), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1; tick = tk;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    d = rdata; re = 1'b0;
  endtask

  task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks_gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_cnt;
    logic [1:0]  exp_raw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rchk("R1 count", A_CNT, 32'h0);
    rchk("R1 match", A_MAT, 32'hFFFF_FFFF);
    rchk("R1 load", A_LD, 32'h0);
    rchk("R1 ctrl", A_CTL, 32'h0);
    rchk("R1 mask", A_MSK, 32'h0);
    rchk("R1 raw", A_RAW, 32'h0);
    rchk("R1 masked", A_MSD, 32'h0);
    rchk("R8 clear reads 0", A_CLR, 32'h0);

    // R3 disabled: no advance
    ticks(12);
    rchk("R3 disabled hold", A_CNT, 32'h0);

    // R10 control exposes bit 26 only
    wr(A_CTL, 32'hFFFF_FFFF);
    rchk("R10 ctrl bit26 only", A_CTL, EN);

    // R2 load readback, R3 divide sweep
    exp_cnt = 32'd100;
    wr(A_LD, exp_cnt);
    rchk("R2 load readback", A_LD, exp_cnt);
    for (int k = 1; k <= 6; k++) begin
      ticks(PS);
      exp_cnt = exp_cnt + 1;
      rchk("R3 contiguous sweep", A_CNT, exp_cnt);
    end
    ticks(PS - 1);
    rchk("R3 partial second", A_CNT, exp_cnt);
    ticks(1);
    exp_cnt = exp_cnt + 1;
    rchk("R3 completes second", A_CNT, exp_cnt);

    // R3 gapped pulses
    ticks_gap(2 * PS);
    exp_cnt = exp_cnt + 2;
    rchk("R3 gapped ticks", A_CNT, exp_cnt);

    // R3 disable mid-run
    ticks(2);
    wr(A_CTL, 32'h0);
    ticks(3 * PS);
    rchk("R3 disabled mid-run", A_CNT, exp_cnt);
    wr(A_CTL, EN);
    ticks(PS - 2);
    exp_cnt = exp_cnt + 1;
    rchk("R3 phase kept across disable", A_CNT, exp_cnt);

    // R2 write to count ignored
    wr(A_CNT, 32'h1234_5678);
    rchk("R2 count write ignored", A_CNT, exp_cnt);

    // R4 load restarts phase
    ticks(2);
    wr(A_LD, 32'd500);
    ticks(PS - 1);
    rchk("R4 restart phase", A_CNT, 32'd500);
    ticks(1);
    rchk("R4 full second after load", A_CNT, 32'd501);

    // R4 load in completion cycle
    ticks(PS - 1);
    wr(A_LD, 32'd800, 1'b1);
    rchk("R4 load beats advance", A_CNT, 32'd800);
    ticks(PS - 1);
    rchk("R4 phase restarted on collision", A_CNT, 32'd800);
    ticks(1);
    rchk("R4 advance after collision", A_CNT, 32'd801);

    // R5 wrap
    wr(A_LD, 32'hFFFF_FFFF);
    ticks(PS);
    rchk("R5 wrap to zero", A_CNT, 32'h0);

    // R8 clear both while no set condition
    wr(A_CLR, 32'h3);
    rchk("R8 clear all", A_RAW, 32'h0);

    // R6 / R7 alarm and periodic
    wr(A_MAT, 32'd2);
    ticks(PS);
    rchk("R7 periodic raw", A_RAW, 32'h2);
    ticks(PS);
    rchk("R6 alarm raw on match", A_RAW, 32'h3);
    rchk("R9 masked with zero mask", A_MSD, 32'h0);
    chk("R9 irq low with zero mask", {31'b0, irq}, 32'h0);

    // R8 set wins while count == match
    wr(A_CLR, 32'h1);
    rchk("R8 set wins over clear", A_RAW, 32'h3);
    wr(A_CLR, 32'h0);
    rchk("R8 zero clear no effect", A_RAW, 32'h3);
    wr(A_CLR, 32'h2);
    rchk("R8 clear periodic bit", A_RAW, 32'h1);

    // R9 mask sweep
    exp_raw = 2'b01;
    for (int m = 0; m < 4; m++) begin
      wr(A_MSK, 32'(m));
      chk("R9 irq vs mask", {31'b0, irq}, {31'b0, |(exp_raw & 2'(m))});
      rchk("R9 masked status", A_MSD, {30'b0, exp_raw & 2'(m)});
      rchk("R9 mask readback", A_MSK, 32'(m));
    end

    // R8 alarm clears once count leaves match
    ticks(PS);
    rchk("R6 alarm latched", A_RAW, 32'h3);
    wr(A_CLR, 32'h1);
    rchk("R8 alarm cleared", A_RAW, 32'h2);
    exp_raw = 2'b10;
    wr(A_MSK, 32'h1);
    chk("R9 irq low after alarm clear", {31'b0, irq}, {31'b0, |(exp_raw & 2'b01)});

    // R8 periodic set wins over same-cycle clear
    wr(A_CLR, 32'h3);
    rchk("R8 all cleared", A_RAW, 32'h0);
    ticks(PS - 1);
    wr(A_CLR, 32'h2, 1'b1);
    rchk("R8 periodic set wins", A_RAW, 32'h2);
    rchk("R3 count after collision", A_CNT, 32'd4);

    // R6 alarm via load
    wr(A_CLR, 32'h3);
    wr(A_MAT, 32'd50);
    wr(A_LD, 32'd50);
    rchk("R6 alarm via load", A_RAW, 32'h1);
    chk("R9 irq high alarm masked in", {31'b0, irq}, 32'h1);
    wr(A_RAW, 32'h0);
    rchk("R2 raw write ignored", A_RAW, 32'h1);

    // R10 unmapped / unaligned
    rchk("R10 unmapped 0x20", 8'h20, 32'h0);
    rchk("R10 unmapped 0x80", 8'h80, 32'h0);
    rchk("R10 unaligned", 8'h05, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule